// File: doc/BRIEF.md
# Local Countdown Timer with Power-of-Two Prescaler

This block is the timer of one processor's local interrupt unit. It counts bus clock cycles (one per `clk` cycle) and, on expiry, raises an interrupt request that carries the vector held in the timer's vector-table entry. A 4-bit divide configuration selects a power-of-two divisor from 1 to 128. Software starts a countdown by writing an initial count, and reads the time left through `cur_count`.

The timer has three modes, all selected by the mode field of the timer entry: one-shot, periodic and timestamp-deadline. In deadline mode the countdown is not used. A 64-bit deadline written through a separate port is compared against a free-running timestamp input. A periodic period shorter than `MIN_PERIOD` cycles is raised to that minimum. Expiries are held in a pending counter until the consumer takes the request with `irq_ack`. A global software enable gates delivery and forces the entry's mask on.

The control is a three-state machine. ST_IDLE means nothing is running. ST_COUNT means a countdown is active. ST_ARMED means a deadline is set. The transitions are:
- START: any state to ST_COUNT, on a nonzero count write.
- STOP: to ST_IDLE, on a zero count write.
- RELOAD: ST_COUNT to ST_COUNT, on periodic expiry.
- FINISH: ST_COUNT to ST_IDLE, on one-shot expiry.
- ARM: to ST_ARMED, on a nonzero deadline write.
- DISARM: to ST_IDLE, on a zero deadline write.
- FIRE: ST_ARMED to ST_IDLE, when the timestamp reaches the deadline.
- CANCEL: any state to ST_IDLE, on a mode change.

Top module: `ltmr_top`

## Requirements
- R1: The divisor is 1 << (({cfg[3],cfg[1],cfg[0]} + 1) mod 8), with the divide configuration written at wr_sel=1. Value 4'hB divides by 1, 4'h0 by 2 and 4'h1 by 4. Bit 2 is ignored, so 4'h4 divides by 2.
- R2: In one-shot or periodic mode, writing a nonzero initial count N (wr_sel=0) starts the countdown, and `cur_count` reads N one cycle after the write edge. `cur_count` reads the remaining cycles divided by the divisor. Expiry occurs N*divisor clock edges after the write edge.
- R3: Writing an initial count of zero stops the timer. `cur_count` then reads 0 and no expiry follows.
- R4: Rewriting the initial count cancels the running countdown and restarts it from the new value. In deadline mode, initial count writes are ignored.
- R5: A timer entry write (wr_sel=2) whose mode field differs from the stored mode cancels the running timer. `cur_count` then reads 0 and no expiry follows.
- R6: Entry bits [18:17] select the mode: 00 one-shot, 01 periodic, 10 deadline. In deadline mode `cur_count` reads 0. A nonzero deadline write arms the timer, which fires at the first edge where `tsc` >= the deadline. A zero deadline disarms it. Deadline writes in other modes are ignored.
- R7: Periodic mode reloads at expiry and keeps running with period max(N*divisor, MIN_PERIOD).
- R8: One-shot mode expires once, then stops with `cur_count` at 0.
- R9: `irq_req` is high, with `irq_vec` equal to entry bits [7:0], whenever the pending count is nonzero, the mask (entry bit 16) is clear and `sw_en` is high. Expiries accumulate in the pending count. Each cycle with `irq_req` and `irq_ack` both high removes one.
- R10: While `sw_en` is low, the entry mask is forced set (including on entry writes) and the pending count is dropped. After `sw_en` returns high, the mask stays set until the entry is rewritten.
- R11: Reset clears the divide configuration (divide by 2) and the initial count, selects one-shot mode with vector 0 and the mask set, and leaves no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one count per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_en | input | 1 | Software enable of the local unit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 initial count, 1 divide configuration, 2 timer entry, 3 none |
| wr_data | input | 32 | Register write data |
| dl_wr | input | 1 | Deadline write strobe |
| dl_data | input | TS_W | Deadline value |
| tsc | input | TS_W | Free-running timestamp |
| irq_ack | input | 1 | Consumer takes the request |
| cur_count | output | CNT_W | Current count read |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 8 | Vector of the request |

## Verification
A wrong remaining-cycle register shows on `cur_count` in the very next cycle after a count write. It also shifts the expiry edge, which the bench checks on both sides of the expected cycle. A lost or extra pending expiry shows as `irq_req` staying high or dropping one acknowledge too early. A stale state after a mode change or disarm shows as a request appearing tens of cycles later, inside windows the bench watches. An error in the divisor decode scales every expiry time, so it shows within a few cycles of the first expected expiry.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;

    typedef enum logic [1:0] {
        MODE_ONCE     = 2'b00,
        MODE_PERIODIC = 2'b01,
        MODE_DEADLINE = 2'b10,
        MODE_RSVD     = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_ARMED = 2'd2
    } tstate_e;

    typedef enum logic [1:0] {
        SEL_INIT  = 2'd0,
        SEL_DIV   = 2'd1,
        SEL_ENTRY = 2'd2,
        SEL_NONE  = 2'd3
    } wsel_e;

    localparam int ENT_MASK_BIT = 16;
    localparam int ENT_MODE_LO  = 17;

    typedef struct packed {
        logic [7:0] vec;
        logic       mask;
        tmode_e     mode;
    } entry_t;

endpackage

// File: rtl/ltmr_regs.sv
module ltmr_regs
    import ltmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_en,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic [2:0]  cfg_q,
    output entry_t      ent_q,
    output logic        init_wr,
    output logic        mode_chg
);
    tmode_e new_mode;
    logic   unused_bits;

    assign new_mode    = tmode_e'(wr_data[ENT_MODE_LO+1:ENT_MODE_LO]);
    assign unused_bits = ^{wr_data[31:19], wr_data[15:8], wr_data[2]};

    // count writes only take effect outside deadline mode
    assign init_wr  = wr_en && (wsel_e'(wr_sel) == SEL_INIT) && (ent_q.mode != MODE_DEADLINE);
    assign mode_chg = wr_en && (wsel_e'(wr_sel) == SEL_ENTRY) && (new_mode != ent_q.mode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= 3'b000;
            ent_q <= '{vec: 8'h00, mask: 1'b1, mode: MODE_ONCE};
        end else begin
            if (wr_en && (wsel_e'(wr_sel) == SEL_DIV)) begin
                cfg_q <= {wr_data[3], wr_data[1], wr_data[0]};
            end
            if (wr_en && (wsel_e'(wr_sel) == SEL_ENTRY)) begin
                ent_q.vec  <= wr_data[7:0];
                ent_q.mode <= new_mode;
                ent_q.mask <= wr_data[ENT_MASK_BIT] | ~sw_en;
            end else if (!sw_en) begin
                ent_q.mask <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ltmr_div.sv
module ltmr_div #(
    parameter int CNT_W      = 32,
    parameter int MIN_PERIOD = 16,
    parameter int CW         = CNT_W + 7
) (
    input  logic [2:0]       cfg,
    input  logic [CNT_W-1:0] init_val,
    input  logic             periodic,
    output logic [2:0]       shift,
    output logic [CW-1:0]    period
);
    logic [CW-1:0] scaled;

    // index wraps in three bits: code 3'b111 gives shift 0
    assign shift  = cfg + 3'd1;
    assign scaled = CW'(init_val) << shift;

    generate
        if (MIN_PERIOD > 0) begin : g_clamp
            localparam logic [CW-1:0] MIN_C = CW'(MIN_PERIOD);
            assign period = (periodic && (scaled < MIN_C)) ? MIN_C : scaled;
        end else begin : g_noclamp
            logic unused_periodic;
            assign unused_periodic = periodic;
            assign period = scaled;
        end
    endgenerate
endmodule

// File: rtl/ltmr_core.sv
module ltmr_core
    import ltmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int TS_W  = 64,
    parameter int CW    = CNT_W + 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_wr,
    input  logic             init_zero,
    input  logic [CW-1:0]    period,
    input  logic             cancel,
    input  tmode_e           mode,
    input  logic [2:0]       shift,
    input  logic             dl_wr,
    input  logic [TS_W-1:0]  dl_data,
    input  logic [TS_W-1:0]  tsc,
    output logic             expire,
    output tstate_e          state,
    output logic [CNT_W-1:0] cnt_out
);
    tstate_e         state_n;
    logic [CW-1:0]   rem, rem_n, per_q, per_n;
    logic [TS_W-1:0] dl_q, dl_n;
    logic            dl_ok;

    assign dl_ok = dl_wr && (mode == MODE_DEADLINE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            rem   <= '0;
            per_q <= '0;
            dl_q  <= '0;
        end else begin
            state <= state_n;
            rem   <= rem_n;
            per_q <= per_n;
            dl_q  <= dl_n;
        end
    end

    // next state and expiry
    always_comb begin
        state_n = state;
        rem_n   = rem;
        per_n   = per_q;
        dl_n    = dl_q;
        expire  = 1'b0;
        if (cancel) begin                           // CANCEL
            state_n = ST_IDLE;
            rem_n   = '0;
        end else if (init_wr) begin
            if (init_zero) begin                    // STOP
                state_n = ST_IDLE;
                rem_n   = '0;
            end else begin                          // START
                state_n = ST_COUNT;
                rem_n   = period;
                per_n   = period;
            end
        end else if (dl_ok) begin
            dl_n = dl_data;
            if (dl_data == '0) begin                // DISARM
                state_n = ST_IDLE;
            end else begin                          // ARM
                state_n = ST_ARMED;
            end
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_COUNT: begin
                    if (rem == CW'(1)) begin
                        expire = 1'b1;
                        if (mode == MODE_PERIODIC) begin   // RELOAD
                            rem_n = per_q;
                        end else begin                     // FINISH
                            state_n = ST_IDLE;
                            rem_n   = '0;
                        end
                    end else begin
                        rem_n = rem - CW'(1);
                    end
                end
                ST_ARMED: begin
                    if (tsc >= dl_q) begin                 // FIRE
                        expire  = 1'b1;
                        state_n = ST_IDLE;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        cnt_out = '0;
        unique case (state)
            ST_COUNT: cnt_out = CNT_W'(rem >> shift);
            ST_IDLE, ST_ARMED: cnt_out = '0;
            default: cnt_out = '0;
        endcase
    end
endmodule

// File: rtl/ltmr_irq.sv
module ltmr_irq #(
    parameter int PEND_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire,
    input  logic       irq_ack,
    input  logic       sw_en,
    input  logic       mask,
    input  logic [7:0] vec,
    output logic       irq_req,
    output logic [7:0] irq_vec
);
    localparam logic [PEND_W-1:0] PEND_MAX = '1;
    logic [PEND_W-1:0] pend;
    logic              take;

    assign irq_req = (pend != '0) && !mask && sw_en;
    assign irq_vec = vec;
    assign take    = irq_req && irq_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (!sw_en) begin
            pend <= '0;
        end else if (expire && !take) begin
            if (pend != PEND_MAX) pend <= pend + 1'b1;
        end else if (take && !expire) begin
            pend <= pend - 1'b1;
        end
    end
endmodule

// File: rtl/ltmr_top.sv
module ltmr_top
    import ltmr_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int TS_W       = 64,
    parameter int MIN_PERIOD = 16,
    parameter int PEND_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_en,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [31:0]      wr_data,
    input  logic             dl_wr,
    input  logic [TS_W-1:0]  dl_data,
    input  logic [TS_W-1:0]  tsc,
    input  logic             irq_ack,
    output logic [CNT_W-1:0] cur_count,
    output logic             irq_req,
    output logic [7:0]       irq_vec
);
    localparam int CW = CNT_W + 7;

    logic [2:0]    cfg_q, shift;
    entry_t        ent_q;
    logic          init_wr, mode_chg, expire;
    logic [CW-1:0] period;
    tstate_e       state;

    ltmr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .cfg_q(cfg_q), .ent_q(ent_q),
        .init_wr(init_wr), .mode_chg(mode_chg)
    );

    ltmr_div #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD), .CW(CW)) u_div (
        .cfg(cfg_q), .init_val(wr_data[CNT_W-1:0]),
        .periodic(ent_q.mode == MODE_PERIODIC), .shift(shift), .period(period)
    );

    ltmr_core #(.CNT_W(CNT_W), .TS_W(TS_W), .CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .init_wr(init_wr),
        .init_zero(wr_data[CNT_W-1:0] == '0), .period(period),
        .cancel(mode_chg), .mode(ent_q.mode), .shift(shift),
        .dl_wr(dl_wr), .dl_data(dl_data), .tsc(tsc),
        .expire(expire), .state(state), .cnt_out(cur_count)
    );

    ltmr_irq #(.PEND_W(PEND_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .expire(expire), .irq_ack(irq_ack),
        .sw_en(sw_en), .mask(ent_q.mask), .vec(ent_q.vec),
        .irq_req(irq_req), .irq_vec(irq_vec)
    );
endmodule

// File: rtl/ltmr_chk.sv
module ltmr_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_en,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [31:0]      wr_data,
    input logic [CNT_W-1:0] cur_count,
    input logic             irq_req,
    input logic             ent_mask,
    input logic [1:0]       ent_mode
);
    p_req_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (!ent_mask && sw_en));

    p_deadline_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_mode == 2'b10) |-> (cur_count == '0));

    p_zero_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && wr_data[CNT_W-1:0] == '0) |=> (cur_count == '0));

    p_mode_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2 && wr_data[18:17] != ent_mode) |=> (cur_count == '0));

    p_force_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en |=> ent_mask);
endmodule

bind ltmr_top ltmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cur_count(cur_count), .irq_req(irq_req),
    .ent_mask(ent_q.mask), .ent_mode(ent_q.mode)
);

// File: tb/ltmr_top_tb.sv
module ltmr_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [31:0] wr_data = '0;
    logic        dl_wr = 1'b0;
    logic [63:0] dl_data = '0;
    logic [63:0] tsc = '0;
    logic        irq_ack = 1'b0;
    logic [31:0] cur_count;
    logic        irq_req;
    logic [7:0]  irq_vec;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        string  rq;
        int     what;
        longint exp;
    } item_t;
    item_t sbq[$];

    always #2 clk = ~clk;
    always @(posedge clk) tsc <= tsc + 64'd1;

    ltmr_top u_dut (
        .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .dl_wr(dl_wr), .dl_data(dl_data), .tsc(tsc),
        .irq_ack(irq_ack), .cur_count(cur_count), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    // scoreboard monitor: compares queued expectations just after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sbq.size() > 0) begin
                item_t it;
                longint act;
                it = sbq.pop_front();
                case (it.what)
                    0: act = longint'(cur_count);
                    1: act = longint'(irq_req);
                    default: act = longint'(irq_vec);
                endcase
                n_cmp++;
                if (act != it.exp) begin
                    n_bad++;
                    $display("FAIL %s sig%0d actual=%0h expected=%0h", it.rq, it.what, act, it.exp);
                end
            end
        end
    end

    function automatic void chk(string rq, int what, longint exp);
        item_t it;
        it.rq = rq; it.what = what; it.exp = exp;
        sbq.push_back(it);
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic wdl(input logic [63:0] v);
        @(negedge clk); dl_wr = 1'b1; dl_data = v;
        @(negedge clk); dl_wr = 1'b0;
    endtask

    task automatic wdl_rel(input int off);
        @(negedge clk); dl_wr = 1'b1; dl_data = tsc + 64'(off);
        @(negedge clk); dl_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic setsw(input logic v);
        @(negedge clk); sw_en = v;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R11 reset count", 0, 0);
        chk("R11 reset req", 1, 0);

        // R11 reset divide-by-2 with one-shot vector 0x40
        setsw(1'b1);
        wr(2'd2, 32'h0000_0040);
        wr(2'd0, 32'd6);
        chk("R2 count after write", 0, 6);
        idle(11); chk("R11 div2 before expiry", 1, 0);
        idle(1);  chk("R11 div2 expiry", 1, 1); chk("R9 vector", 2, 8'h40);
        ack();    chk("R9 ack clears", 1, 0);

        // R1 divide by 1
        wr(2'd1, 32'hB);
        wr(2'd0, 32'd10);
        chk("R2 count reads N", 0, 10);
        idle(9);  chk("R2 before expiry", 1, 0);
        idle(1);  chk("R2 expiry", 1, 1); chk("R8 one-shot count zero", 0, 0);
        idle(20); chk("R9 pending held", 1, 1);
        ack();    chk("R9 ack", 1, 0);
        idle(20); chk("R8 no second expiry", 1, 0);

        // R1 divide by 4
        wr(2'd1, 32'h1);
        wr(2'd0, 32'd3);
        chk("R1 div4 count", 0, 3);
        idle(1);  chk("R1 div4 scaled count", 0, 2);
        idle(10); chk("R1 div4 before expiry", 1, 0);
        idle(1);  chk("R1 div4 expiry", 1, 1);
        ack();

        // R1 bit 2 ignored
        wr(2'd1, 32'h4);
        wr(2'd0, 32'd4);
        idle(7);  chk("R1 bit2 ignored before", 1, 0);
        idle(1);  chk("R1 bit2 ignored expiry", 1, 1);
        ack();

        // R3 zero count
        wr(2'd1, 32'hB);
        wr(2'd0, 32'd0);
        chk("R3 zero count reads 0", 0, 0);
        idle(30); chk("R3 no expiry", 1, 0);

        // R4 restart
        wr(2'd0, 32'd20);
        idle(5);  chk("R4 counting", 0, 15);
        wr(2'd0, 32'd8);
        chk("R4 restarted", 0, 8);
        idle(7);  chk("R4 before new expiry", 1, 0);
        idle(1);  chk("R4 new expiry", 1, 1);
        ack();

        // R5 mode change cancels
        wr(2'd0, 32'd50);
        idle(3);
        wr(2'd2, 32'h0002_009C);
        chk("R5 cancelled count", 0, 0);
        idle(60); chk("R5 no expiry", 1, 0);

        // R7 periodic reload
        wr(2'd0, 32'd20);
        idle(19); chk("R7 before first", 1, 0);
        idle(1);  chk("R7 first expiry", 1, 1); chk("R9 vector 9C", 2, 8'h9C);
        ack();    chk("R7 ack", 1, 0);
        idle(17); chk("R7 before second", 1, 0);
        idle(1);  chk("R7 second expiry", 1, 1); chk("R7 reloaded count", 0, 20);
        ack();

        // R7 clamp to MIN_PERIOD=16, R9 accumulation
        wr(2'd0, 32'd4);
        chk("R7 clamped count", 0, 16);
        idle(15); chk("R7 clamp before", 1, 0);
        idle(1);  chk("R7 clamp expiry", 1, 1);
        idle(16);
        ack();    chk("R9 second pending remains", 1, 1);
        ack();    chk("R9 pending drained", 1, 0);

        // R6 deadline mode
        wr(2'd2, 32'h0004_0040);
        chk("R6 deadline count zero", 0, 0);
        wr(2'd0, 32'd5);
        chk("R4 count ignored in deadline", 0, 0);
        idle(20); chk("R4 no expiry in deadline", 1, 0);
        wdl_rel(10);
        idle(9);  chk("R6 before deadline", 1, 0);
        idle(1);  chk("R6 deadline fires", 1, 1); chk("R6 count zero", 0, 0);
        ack();
        wdl_rel(8);
        wdl(64'd0);
        idle(20); chk("R6 disarmed", 1, 0);
        wdl(64'd1);
        chk("R6 past deadline not yet", 1, 0);
        idle(1);  chk("R6 past deadline fires", 1, 1);
        ack();
        wr(2'd2, 32'h0000_0040);
        wdl(64'd1);
        idle(5);  chk("R6 deadline ignored in one-shot", 1, 0);

        // R10 software enable
        wr(2'd0, 32'd5);
        idle(5);  chk("R10 setup expiry", 1, 1);
        setsw(1'b0); chk("R10 req gated", 1, 0);
        idle(1);
        setsw(1'b1); chk("R10 pending dropped", 1, 0);
        wr(2'd0, 32'd3);
        idle(3);  chk("R10 mask forced", 1, 0);
        wr(2'd2, 32'h0000_0040);
        chk("R9 held pending after unmask", 1, 1);
        ack();    chk("R9 drained", 1, 0);
        setsw(1'b0);
        wr(2'd2, 32'h0000_0040);
        setsw(1'b1);
        wr(2'd0, 32'd2);
        idle(3);  chk("R10 entry write while disabled masked", 1, 0);

        idle(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule